// File: doc/BRIEF.md
# Load Alignment and Byte-Lane Unit

This unit sits between a doubleword-wide data memory port and the register file. For every request it receives the low bits of the byte address (the offset inside the 8-byte doubleword), an access size of one, two, four or eight bytes, a signed flag and a run-time endianness select. The upper address bits go straight to the memory and never pass through this unit.

An access whose offset is not a multiple of its size is refused. The unit raises a one-cycle fault and delivers no data for it. For an aligned load, the unit picks the addressed byte lanes out of the memory doubleword, orders them by the selected endianness and widens them to 64 bits with sign or zero fill. For an aligned store, the unit replicates the source value into every slot of the access size and enables only the addressed lanes. All results are registered and appear one cycle after the request.

Top module: `lane_access_unit`

## Requirements
- R1: A synchronous active-high reset clears rsp_valid, rsp_fault, ld_result, st_wdata and st_byte_en to zero.
- R2: A request accepted at a clock edge with req_valid high produces its outcome at the next edge. rsp_valid or rsp_fault is then high for exactly one cycle per request, and back-to-back requests give back-to-back outcomes.
- R3: req_size encodes 0 = byte, 1 = halfword, 2 = word and 3 = doubleword. A byte is aligned at every offset 0 to 7, a halfword only at offsets 0, 2, 4 and 6, a word only at 0 and 4, and a doubleword only at 0. An aligned request gives rsp_valid and never rsp_fault. A misaligned one gives rsp_fault and never rsp_valid.
- R4: A misaligned request leaves ld_result at its previous value and drives st_byte_en to all zeros in its fault cycle.
- R5: Memory byte lane k is mem_rdata[8k+7:8k] and holds the byte at offset k. With req_big_endian low, a load places the byte at the access offset in the least significant position of the result.
- R6: With req_big_endian high, a load places the byte at the access offset in the most significant position of the loaded value.
- R7: A load narrower than 64 bits fills the upper result bits with copies of the loaded value's top bit when req_signed is high, and with zeros otherwise. A doubleword load returns all 64 bits the same under either setting of req_signed.
- R8: An aligned store sets st_byte_en bit k high for exactly the lanes from the offset up to offset plus size minus one, so the number of bits set equals the access size in bytes.
- R9: An aligned store drives st_wdata with the low size bytes of st_data copied into every size-wide slot of the doubleword. Each slot is byte-ordered so that a load of the same size, offset and endianness would return those bytes.
- R10: A store leaves ld_result unchanged, and a load leaves st_byte_en all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_byte_off | input | 3 | Byte offset of the address inside the doubleword |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_big_endian | input | 1 | 1 = big-endian lane order, 0 = little-endian |
| mem_rdata | input | 64 | Doubleword read from memory, lane k at bits 8k+7:8k |
| st_data | input | 64 | Store source value, right-aligned |
| rsp_valid | output | 1 | Aligned request completed (one cycle) |
| rsp_fault | output | 1 | Misaligned request refused (one cycle) |
| ld_result | output | 64 | Extended load value, held between loads |
| st_wdata | output | 64 | Replicated store data for the memory |
| st_byte_en | output | 8 | Per-lane store write enables |

## Verification
A wrong lane-index computation shows up at ld_result or st_wdata in the cycle after the offending request. It appears as a byte from the neighbouring lane, or as a swapped byte order in one endianness mode only, so the vectors cover both modes at non-zero offsets. A wrong alignment mask shows up one cycle after the request, as rsp_fault where rsp_valid was due or the other way round. A fault path that lets state through shows up in that same cycle, as a changed ld_result or a non-zero st_byte_en. Because the only state is the output register, every internal error becomes visible at the ports within one cycle.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANES  = 8;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic             is_store;
        acc_size_e        size;
        logic             sext;
        logic             big_end;
        logic [OFF_W-1:0] off;
    } acc_req_t;

    // Number of bytes moved by an access of the given size.
    function automatic logic [OFF_W:0] size_bytes(acc_size_e s);
        return (OFF_W+1)'(1) << s;
    endfunction

    // Offset bits that must be zero for an aligned access.
    function automatic logic [OFF_W-1:0] size_mask(acc_size_e s);
        logic [OFF_W:0] m;
        m = size_bytes(s) - (OFF_W+1)'(1);
        return m[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
    import lane_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);

    assign misaligned = |(off & size_mask(size));

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
    import lane_pkg::*;
(
    input  logic [DATA_W-1:0] rdata,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sext,
    input  logic              big_end,
    output logic [DATA_W-1:0] value
);

    logic [OFF_W-1:0]  mask;
    logic [BYTE_W-1:0] picked [LANES];
    logic              fill;

    assign mask = size_mask(size);

    // Byte i of the loaded value comes from lane off + rel(i); the relative
    // index runs backwards inside the access when big-endian is selected.
    for (genvar i = 0; i < LANES; i++) begin : g_pick
        logic [OFF_W-1:0] rel;
        logic [OFF_W-1:0] lane;
        assign rel       = big_end ? (~OFF_W'(i) & mask) : (OFF_W'(i) & mask);
        assign lane      = off + rel;
        assign picked[i] = rdata[{lane, 3'b000} +: BYTE_W];
    end

    assign fill = sext & picked[mask][BYTE_W-1];

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        assign value[i*BYTE_W +: BYTE_W] = (OFF_W'(i) <= mask) ? picked[i]
                                                               : {BYTE_W{fill}};
    end

endmodule

// File: rtl/lane_store_format.sv
module lane_store_format
    import lane_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              big_end,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  byte_en
);

    logic [OFF_W-1:0] mask;

    assign mask = size_mask(size);

    // Lane k carries source byte (k mod size), reversed per slot when
    // big-endian; it is enabled when it falls in the slot at the offset.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W-1:0] rel;
        assign rel = big_end ? (~OFF_W'(k) & mask) : (OFF_W'(k) & mask);
        assign wdata[k*BYTE_W +: BYTE_W] = src[{rel, 3'b000} +: BYTE_W];
        assign byte_en[k] = ((OFF_W'(k) & ~mask) == (off & ~mask));
    end

endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
    import lane_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic                     req_is_store,
    input  logic [lane_pkg::OFF_W-1:0]  req_byte_off,
    input  logic [1:0]               req_size,
    input  logic                     req_signed,
    input  logic                     req_big_endian,
    input  logic [lane_pkg::DATA_W-1:0] mem_rdata,
    input  logic [lane_pkg::DATA_W-1:0] st_data,
    output logic                     rsp_valid,
    output logic                     rsp_fault,
    output logic [lane_pkg::DATA_W-1:0] ld_result,
    output logic [lane_pkg::DATA_W-1:0] st_wdata,
    output logic [lane_pkg::LANES-1:0]  st_byte_en
);

    acc_req_t          req;
    logic              mis;
    logic              take_load;
    logic              take_store;
    logic [DATA_W-1:0] ld_next;
    logic [DATA_W-1:0] wd_next;
    logic [LANES-1:0]  en_next;

    assign req = '{is_store: req_is_store,
                   size:     acc_size_e'(req_size),
                   sext:     req_signed,
                   big_end:  req_big_endian,
                   off:      req_byte_off};

    lane_align_check u_align (
        .size       (req.size),
        .off        (req.off),
        .misaligned (mis)
    );

    lane_load_extract u_load (
        .rdata   (mem_rdata),
        .size    (req.size),
        .off     (req.off),
        .sext    (req.sext),
        .big_end (req.big_end),
        .value   (ld_next)
    );

    lane_store_format u_store (
        .src     (st_data),
        .size    (req.size),
        .off     (req.off),
        .big_end (req.big_end),
        .wdata   (wd_next),
        .byte_en (en_next)
    );

    assign take_load  = req_valid & ~mis & ~req.is_store;
    assign take_store = req_valid & ~mis &  req.is_store;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            ld_result  <= '0;
            st_wdata   <= '0;
            st_byte_en <= '0;
        end else begin
            rsp_valid  <= req_valid & ~mis;
            rsp_fault  <= req_valid &  mis;
            st_byte_en <= take_store ? en_next : '0;
            if (take_store) st_wdata  <= wd_next;
            if (take_load)  ld_result <= ld_next;
        end
    end

endmodule

// File: rtl/lane_access_chk.sv
module lane_access_chk
    import lane_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_store,
    input logic [OFF_W-1:0]  req_byte_off,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DATA_W-1:0] ld_result,
    input logic [LANES-1:0]  st_byte_en
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_fault)); // R3

    AST_OUTCOME_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || rsp_fault) |-> $past(req_valid)); // R2

    AST_BYTE_NEVER_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd0) |=> (rsp_valid && !rsp_fault)); // R3

    AST_DWORD_OFFSET_FAULTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3 && req_byte_off != '0) |=> rsp_fault); // R3

    AST_FAULT_NO_ENABLES: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (st_byte_en == '0)); // R4

    AST_FAULT_HOLDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> $stable(ld_result)); // R4

    AST_ENABLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && $past(req_is_store)) |->
            ($countones(st_byte_en) == (1 << $past(req_size)))); // R8

    AST_LOAD_NO_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(req_is_store)) |-> (st_byte_en == '0)); // R10

endmodule

bind lane_access_unit lane_access_chk u_chk (.*);

// File: tb/lane_access_unit_bench.sv
`timescale 1ns/1ps
module lane_access_unit_bench;

    localparam logic [63:0] MEM = 64'hF1E2_D3C4_B5A6_9788;
    localparam logic [63:0] SRC = 64'h0123_4567_89AB_CDEF;
    localparam int NV = 26;

    // {store, size, signed, big_endian, offset, fault, data, byte_en}
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 2'd0, 1'b0, 1'b0, 3'd3, 1'b0, 64'h0000_0000_0000_00B5, 8'h00},
        {1'b0, 2'd0, 1'b1, 1'b0, 3'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFB5, 8'h00},
        {1'b0, 2'd0, 1'b1, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FF88, 8'h00},
        {1'b0, 2'd1, 1'b0, 1'b0, 3'd2, 1'b0, 64'h0000_0000_0000_B5A6, 8'h00},
        {1'b0, 2'd1, 1'b1, 1'b1, 3'd2, 1'b0, 64'hFFFF_FFFF_FFFF_A6B5, 8'h00},
        {1'b0, 2'd2, 1'b1, 1'b0, 3'd4, 1'b0, 64'hFFFF_FFFF_F1E2_D3C4, 8'h00},
        {1'b0, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0, 64'h0000_0000_C4D3_E2F1, 8'h00},
        {1'b0, 2'd2, 1'b1, 1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF_8897_A6B5, 8'h00},
        {1'b0, 2'd3, 1'b1, 1'b0, 3'd0, 1'b0, 64'hF1E2_D3C4_B5A6_9788, 8'h00},
        {1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 1'b0, 64'hF1E2_D3C4_B5A6_9788, 8'h00},
        {1'b0, 2'd3, 1'b1, 1'b1, 3'd0, 1'b0, 64'h8897_A6B5_C4D3_E2F1, 8'h00},
        {1'b0, 2'd0, 1'b0, 1'b0, 3'd7, 1'b0, 64'h0000_0000_0000_00F1, 8'h00},
        {1'b0, 2'd1, 1'b0, 1'b1, 3'd6, 1'b0, 64'h0000_0000_0000_E2F1, 8'h00},
        {1'b0, 2'd1, 1'b0, 1'b0, 3'd1, 1'b1, 64'h0,                   8'h00},
        {1'b0, 2'd2, 1'b1, 1'b0, 3'd2, 1'b1, 64'h0,                   8'h00},
        {1'b0, 2'd2, 1'b0, 1'b1, 3'd6, 1'b1, 64'h0,                   8'h00},
        {1'b0, 2'd3, 1'b0, 1'b0, 3'd4, 1'b1, 64'h0,                   8'h00},
        {1'b1, 2'd0, 1'b0, 1'b0, 3'd5, 1'b0, 64'hEFEF_EFEF_EFEF_EFEF, 8'h20},
        {1'b1, 2'd1, 1'b0, 1'b0, 3'd6, 1'b0, 64'hCDEF_CDEF_CDEF_CDEF, 8'hC0},
        {1'b1, 2'd1, 1'b0, 1'b1, 3'd2, 1'b0, 64'hEFCD_EFCD_EFCD_EFCD, 8'h0C},
        {1'b1, 2'd2, 1'b0, 1'b0, 3'd4, 1'b0, 64'h89AB_CDEF_89AB_CDEF, 8'hF0},
        {1'b1, 2'd2, 1'b0, 1'b1, 3'd0, 1'b0, 64'hEFCD_AB89_EFCD_AB89, 8'h0F},
        {1'b1, 2'd3, 1'b0, 1'b1, 3'd0, 1'b0, 64'hEFCD_AB89_6745_2301, 8'hFF},
        {1'b1, 2'd3, 1'b0, 1'b0, 3'd3, 1'b1, 64'h0,                   8'h00},
        {1'b1, 2'd1, 1'b0, 1'b1, 3'd7, 1'b1, 64'h0,                   8'h00},
        {1'b0, 2'd1, 1'b1, 1'b0, 3'd6, 1'b0, 64'hFFFF_FFFF_FFFF_F1E2, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_is_store = 1'b0;
    logic [2:0]  req_byte_off = '0;
    logic [1:0]  req_size = '0;
    logic        req_signed = 1'b0;
    logic        req_big_endian = 1'b0;
    logic [63:0] mem_rdata = MEM;
    logic [63:0] st_data = SRC;
    logic        rsp_valid, rsp_fault;
    logic [63:0] ld_result, st_wdata;
    logic [7:0]  st_byte_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] last_ld = '0;

    always #4 clk = ~clk;

    lane_access_unit u_lane_access_unit (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic [1:0] sz, input logic sg,
                         input logic be, input logic [2:0] off);
        req_valid      = 1'b1;
        req_is_store   = st;
        req_size       = sz;
        req_signed     = sg;
        req_big_endian = be;
        req_byte_off   = off;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(rsp_valid === 1'b0 && rsp_fault === 1'b0, "R1 flags", {62'd0, rsp_valid, rsp_fault}, 64'd0);
        chk(ld_result === 64'd0, "R1 ld_result", ld_result, 64'd0);
        chk(st_wdata === 64'd0, "R1 st_wdata", st_wdata, 64'd0);
        chk(st_byte_en === 8'd0, "R1 st_byte_en", {56'd0, st_byte_en}, 64'd0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [80:0] e;
            e = VEC[v];
            @(negedge clk);
            drive(e[80], e[79:78], e[77], e[76], e[75:73]);
            @(negedge clk);
            req_valid = 1'b0;
            chk(rsp_fault === e[72], "R3 fault", {63'd0, rsp_fault}, {63'd0, e[72]});
            chk(rsp_valid === !e[72], "R2 R3 valid", {63'd0, rsp_valid}, {63'd0, !e[72]});
            if (e[72]) begin
                chk(ld_result === last_ld, "R4 load held", ld_result, last_ld);
                chk(st_byte_en === 8'd0, "R4 no enables", {56'd0, st_byte_en}, 64'd0);
            end else if (e[80]) begin
                chk(st_byte_en === e[7:0], "R8 enables", {56'd0, st_byte_en}, {56'd0, e[7:0]});
                chk(st_wdata === e[71:8], "R9 store data", st_wdata, e[71:8]);
                chk(ld_result === last_ld, "R10 store keeps load", ld_result, last_ld);
            end else begin
                chk(ld_result === e[71:8], e[76] ? "R6 R7 load" : "R5 R7 load", ld_result, e[71:8]);
                chk(st_byte_en === 8'd0, "R10 load no enables", {56'd0, st_byte_en}, 64'd0);
                last_ld = e[71:8];
            end
        end

        // R2: outcome lasts exactly one cycle
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 1'b0, 3'd4);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid === 1'b1, "R2 pulse high", {63'd0, rsp_valid}, 64'd1);
        chk(ld_result === 64'hC4, "R5 byte lane 4", ld_result, 64'hC4);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R2 pulse low", {63'd0, rsp_valid}, 64'd0);

        // R2: back-to-back requests
        drive(1'b0, 2'd1, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        chk(rsp_valid === 1'b1 && ld_result === 64'h9788, "R2 first of pair", ld_result, 64'h9788);
        drive(1'b0, 2'd1, 1'b0, 1'b0, 3'd3);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_fault === 1'b1 && rsp_valid === 1'b0, "R2 second of pair", {62'd0, rsp_valid, rsp_fault}, 64'd1);
        chk(ld_result === 64'h9788, "R4 held after pair", ld_result, 64'h9788);
        last_ld = 64'h9788;

        // R3: full sweep of sizes and offsets
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
                bit exp_f;
                exp_f = (off & ((1 << sz) - 1)) != 0;
                @(negedge clk);
                drive(1'b1, 2'(sz), 1'b0, 1'b0, 3'(off));
                @(negedge clk);
                req_valid = 1'b0;
                chk(rsp_fault === exp_f && rsp_valid === !exp_f, "R3 sweep",
                    {56'd0, 2'(sz), 3'(off), 1'b0, rsp_valid, rsp_fault},
                    {56'd0, 2'(sz), 3'(off), 1'b0, !exp_f, exp_f});
            end
        end

        // R1: reset in mid-run clears a loaded value
        @(negedge clk);
        drive(1'b0, 2'd3, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        req_valid = 1'b0;
        chk(ld_result === MEM, "R5 doubleword", ld_result, MEM);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ld_result === 64'd0 && st_wdata === 64'd0, "R1 mid-run reset", ld_result, 64'd0);

        done = 1'b1;
        finish_run();
    end

endmodule